// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This block is the arithmetic and logic unit of an 8-bit accumulator machine, together with the register that holds its processor status byte. Each cycle it takes two operands, a carry-in, an operation code and a flag mask. It forms the result combinationally. It also forms the value the status byte would take if the operation were committed. When the update enable is high, that value is written into the status register on the next rising clock edge.

Every operation owns a fixed subset of the negative (N), overflow (V), zero (Z) and carry (C) flags, or exactly one of the mode flags D or I. A flag is written only when the operation owns it and its bit in the flag mask is set. The other status bits keep their stored value.

The status byte is laid out as follows: N in bit 7, V in bit 6, a constant 1 in bit 5, B in bit 4, D in bit 3, I in bit 2, Z in bit 1 and C in bit 0. Decimal arithmetic, instruction decoding and memory access are handled elsewhere.

Top module: `alu8_top`

## Requirements
- R1: Operation code 0 (add) gives result = (opa + opb + cin) mod 256. It writes C with the carry out of bit 7. It sets V when opa and opb share a sign bit and the result sign differs. It writes N from result bit 7 and sets Z when the result is zero.
- R2: Operation code 1 (subtract) computes opa + ~opb + cin, so cin = 1 means no borrow. C is the carry out. V is found as in R1 using ~opb. N and Z are taken from the result.
- R3: Codes 2 (AND), 3 (OR), 4 (XOR), 9 (increment opa), 10 (decrement opa) and 13 (transfer, result = opb) write only N and Z from the result. V and C keep their stored values.
- R4: Code 5 (shift left) gives {opa[6:0],0} with C = opa[7]. Code 6 (shift right) gives {0,opa[7:1]} with C = opa[0], which forces N to 0. Both write N, Z and C.
- R5: Code 7 (rotate left) gives {opa[6:0],cin} with C = opa[7]. Code 8 (rotate right) gives {cin,opa[7:1]} with C = opa[0]. Both write N, Z and C.
- R6: Code 11 (compare) writes N, Z and C from opa + ~opb + 1. It leaves V unchanged and outputs opa unchanged as the result.
- R7: Code 12 (bit test) sets N = opb[7], V = opb[6] and Z = ((opa & opb) == 0). It leaves C unchanged and outputs opa as the result.
- R8: Codes 14/15 clear/set C, 16 clears V, 17/18 clear/set D, and 19/20 clear/set I. Each of these changes only its own flag and outputs opa as the result.
- R9: A flag bit is written only when its bit in flag_mask is 1. A flag whose mask bit is 0 keeps its value.
- R10: When upd_en is high, status takes the value of flags_next on the next rising clock edge. When upd_en is low, status holds.
- R11: Status bit 5 always reads 1. While reset is active, and after it, until the first write, status is 8'h20. Reset asserts asynchronously and is released two clock edges after rst_n rises.
- R12: Unused operation codes (21 to 31) output opa and write no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 5 | Operation code |
| opa | input | 8 | First operand (accumulator side) |
| opb | input | 8 | Second operand |
| cin | input | 1 | Carry-in for add, subtract and rotates |
| flag_mask | input | 8 | Per-bit permission to write status flags |
| upd_en | input | 1 | Commit flags_next into status at the clock edge |
| result | output | 8 | Combinational result |
| flags_next | output | 8 | Status value this operation would commit |
| status | output | 8 | Registered status byte |

## Verification
The result output is combinational, so a fault in the adder, shifter or result selection shows at the ports in the same cycle the operands are driven. A fault in flag ownership or in the mask merge does not show in the result. It appears in flags_next at once and in status one edge later, when upd_en is high. A wrong flag that nothing reads for a while can stay hidden until an operation reveals it. For that reason the bench preloads V and C with known values before each logic, compare and bit-test operation, and it compares the whole status byte after every cycle.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW        = 8;
  localparam int OPW       = 5;
  localparam int FL_N      = 7;
  localparam int FL_V      = 6;
  localparam int FL_ONE    = 5;
  localparam int FL_B      = 4;
  localparam int FL_D      = 3;
  localparam int FL_I      = 2;
  localparam int FL_Z      = 1;
  localparam int FL_C      = 0;
  localparam logic [7:0] ST_RESET = 8'h20;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,
    OP_SUB  = 5'd1,
    OP_AND  = 5'd2,
    OP_OR   = 5'd3,
    OP_XOR  = 5'd4,
    OP_SHL  = 5'd5,
    OP_SHR  = 5'd6,
    OP_ROTL = 5'd7,
    OP_ROTR = 5'd8,
    OP_INC  = 5'd9,
    OP_DEC  = 5'd10,
    OP_CMP  = 5'd11,
    OP_TST  = 5'd12,
    OP_MOV  = 5'd13,
    OP_CLRC = 5'd14,
    OP_SETC = 5'd15,
    OP_CLRV = 5'd16,
    OP_CLRD = 5'd17,
    OP_SETD = 5'd18,
    OP_CLRI = 5'd19,
    OP_SETI = 5'd20
  } alu_op_e;
endpackage

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = DW
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic [7:0]   val
);
  localparam int MSB = W - 1;

  logic [W:0]   sum;
  logic [W-1:0] addend;
  logic [W-1:0] nz_src;
  logic         cadd, ovf, n_b, v_b, z_b, c_b, d_b, i_b, tst_sel;

  always_comb begin
    addend = (op == OP_ADD) ? b : ~b;
    cadd   = (op == OP_CMP) ? 1'b1 : cin;
    sum    = {1'b0, a} + {1'b0, addend} + {{W{1'b0}}, cadd};
    ovf    = (a[MSB] == addend[MSB]) && (sum[MSB] != a[MSB]);
  end

  always_comb begin
    res     = a;
    nz_src  = a;
    c_b     = 1'b0;
    v_b     = 1'b0;
    d_b     = 1'b0;
    i_b     = 1'b0;
    tst_sel = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        res = sum[W-1:0]; c_b = sum[W]; v_b = ovf;
      end
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_INC:  res = a + W'(1);
      OP_DEC:  res = a - W'(1);
      OP_MOV:  res = b;
      OP_SHL:  begin res = {a[MSB-1:0], 1'b0}; c_b = a[MSB]; end
      OP_SHR:  begin res = {1'b0, a[MSB:1]};   c_b = a[0];   end
      OP_ROTL: begin res = {a[MSB-1:0], cin};  c_b = a[MSB]; end
      OP_ROTR: begin res = {cin, a[MSB:1]};    c_b = a[0];   end
      OP_CMP:  c_b = sum[W];
      OP_TST:  tst_sel = 1'b1;
      OP_SETC: c_b = 1'b1;
      OP_SETD: d_b = 1'b1;
      OP_SETI: i_b = 1'b1;
      default: ;
    endcase
    nz_src = (op == OP_CMP) ? sum[W-1:0] : res;
  end

  always_comb begin
    n_b = tst_sel ? b[MSB] : nz_src[MSB];
    z_b = tst_sel ? ~|(a & b) : ~|nz_src;
    val         = 8'h00;
    val[FL_N]   = n_b;
    val[FL_V]   = tst_sel ? b[MSB-1] : v_b;
    val[FL_ONE] = 1'b1;
    val[FL_D]   = d_b;
    val[FL_I]   = i_b;
    val[FL_Z]   = z_b;
    val[FL_C]   = c_b;
  end
endmodule

// File: rtl/alu8_flagsel.sv
module alu8_flagsel
  import alu8_pkg::*;
(
  input  alu_op_e    op,
  input  logic [7:0] val,
  input  logic [7:0] mask,
  input  logic [7:0] cur,
  output logic [7:0] nxt
);
  logic [7:0] own, wr;

  always_comb begin
    own = 8'h00;
    unique case (op)
      OP_ADD, OP_SUB:                           own = 8'hC3;
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC,
      OP_MOV:                                   own = 8'h82;
      OP_SHL, OP_SHR, OP_ROTL, OP_ROTR, OP_CMP: own = 8'h83;
      OP_TST:                                   own = 8'hC2;
      OP_CLRC, OP_SETC:                         own[FL_C] = 1'b1;
      OP_CLRV:                                  own[FL_V] = 1'b1;
      OP_CLRD, OP_SETD:                         own[FL_D] = 1'b1;
      OP_CLRI, OP_SETI:                         own[FL_I] = 1'b1;
      default:                                  own = 8'h00;
    endcase
    wr          = own & mask;
    nxt         = (cur & ~wr) | (val & wr);
    nxt[FL_ONE] = 1'b1;
  end
endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [7:0] nxt,
  output logic [7:0] q
);
  logic [7:0] st_d, st_q;

  always_comb begin
    st_d = en ? nxt : st_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RESET;
    else        st_q <= st_d;
  end

  assign q = st_q;

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(st_q));

  assert_fixed_one_R11: assert property (@(posedge clk) disable iff (!rst_n)
    st_q[FL_ONE] == 1'b1);
endmodule

// File: rtl/alu8_top.sv
module alu8_top
  import alu8_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] op,
  input  logic [7:0] opa,
  input  logic [7:0] opb,
  input  logic       cin,
  input  logic [7:0] flag_mask,
  input  logic       upd_en,
  output logic [7:0] result,
  output logic [7:0] flags_next,
  output logic [7:0] status
);
  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_s;
  logic [7:0]             raw_val;
  alu_op_e                op_e;

  assign op_e = alu_op_e'(op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s = rst_sync[SYNC_STAGES-1];

  alu8_core #(.W(DW)) u_core (
    .op (op_e),
    .a  (opa),
    .b  (opb),
    .cin(cin),
    .res(result),
    .val(raw_val)
  );

  alu8_flagsel u_flagsel (
    .op  (op_e),
    .val (raw_val),
    .mask(flag_mask),
    .cur (status),
    .nxt (flags_next)
  );

  alu8_status u_status (
    .clk  (clk),
    .rst_n(rst_s),
    .en   (upd_en),
    .nxt  (flags_next),
    .q    (status)
  );

  assert_commit_R10: assert property (@(posedge clk) disable iff (!rst_s)
    upd_en |=> status == $past(flags_next));

  assert_logic_keeps_vc_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (upd_en && (op_e inside {OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC, OP_MOV}))
    |=> (status[FL_V] == $past(status[FL_V])) && (status[FL_C] == $past(status[FL_C])));

  assert_shr_clears_n_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (upd_en && op_e == OP_SHR && flag_mask[FL_N]) |=> !status[FL_N]);

  assert_cmp_keeps_opa_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (op_e == OP_CMP) |-> result == opa);

  assert_mask_blocks_c_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (upd_en && !flag_mask[FL_C]) |=> status[FL_C] == $past(status[FL_C]));
endmodule

// File: tb/alu8_top_tb.sv
`timescale 1ns/1ps
module alu8_top_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] op;
  logic [7:0] opa, opb, flag_mask;
  logic       cin, upd_en;
  logic [7:0] result, flags_next, status;

  int checks = 0;
  int errors = 0;
  bit driving_done = 0;

  typedef struct {
    logic [7:0] res;
    logic [7:0] st;
    string      tag;
  } exp_t;
  exp_t sb[$];
  logic [7:0] model_st;

  always #2 clk = ~clk;

  alu8_top u_dut (
    .clk(clk), .rst_n(rst_n), .op(op), .opa(opa), .opb(opb), .cin(cin),
    .flag_mask(flag_mask), .upd_en(upd_en), .result(result),
    .flags_next(flags_next), .status(status)
  );

  function automatic string tag_of(input logic [4:0] o);
    case (o)
      5'd0: return "R1";
      5'd1: return "R2";
      5'd2, 5'd3, 5'd4, 5'd9, 5'd10, 5'd13: return "R3";
      5'd5, 5'd6: return "R4";
      5'd7, 5'd8: return "R5";
      5'd11: return "R6";
      5'd12: return "R7";
      default: return (o <= 5'd20) ? "R8" : "R12";
    endcase
  endfunction

  function automatic void model(input logic [4:0] o, input logic [7:0] a, input logic [7:0] b,
                                input logic ci, input logic [7:0] m, input logic en,
                                input logic [7:0] st, output logic [7:0] r, output logic [7:0] ns);
    logic [8:0] t;
    logic [7:0] bb, w, v;
    v = 8'h00; w = 8'h00; r = a;
    case (o)
      5'd0, 5'd1: begin
        bb = (o == 5'd0) ? b : ~b;
        t = {1'b0, a} + {1'b0, bb} + {8'h00, ci};
        r = t[7:0]; w = 8'hC3;
        v[0] = t[8]; v[6] = (a[7] == bb[7]) && (r[7] != a[7]);
        v[7] = r[7]; v[1] = (r == 8'h00);
      end
      5'd2, 5'd3, 5'd4, 5'd9, 5'd10, 5'd13: begin
        case (o)
          5'd2: r = a & b;
          5'd3: r = a | b;
          5'd4: r = a ^ b;
          5'd9: r = a + 8'd1;
          5'd10: r = a - 8'd1;
          default: r = b;
        endcase
        w = 8'h82; v[7] = r[7]; v[1] = (r == 8'h00);
      end
      5'd5, 5'd6, 5'd7, 5'd8: begin
        case (o)
          5'd5: begin r = a << 1; v[0] = a[7]; end
          5'd6: begin r = a >> 1; v[0] = a[0]; end
          5'd7: begin r = {a[6:0], ci}; v[0] = a[7]; end
          default: begin r = {ci, a[7:1]}; v[0] = a[0]; end
        endcase
        w = 8'h83; v[7] = r[7]; v[1] = (r == 8'h00);
      end
      5'd11: begin
        t = {1'b0, a} - {1'b0, b};
        w = 8'h83; v[0] = (a >= b); v[7] = t[7]; v[1] = (a == b);
      end
      5'd12: begin
        w = 8'hC2; v[7] = b[7]; v[6] = b[6]; v[1] = ((a & b) == 8'h00);
      end
      5'd14: w = 8'h01;
      5'd15: begin w = 8'h01; v = 8'h01; end
      5'd16: w = 8'h40;
      5'd17: w = 8'h08;
      5'd18: begin w = 8'h08; v = 8'h08; end
      5'd19: w = 8'h04;
      5'd20: begin w = 8'h04; v = 8'h04; end
      default: w = 8'h00;
    endcase
    w = w & m;
    ns = en ? (((st & ~w) | (v & w)) | 8'h20) : st;
  endfunction

  task automatic drive(input logic [4:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic ci, input logic [7:0] m, input logic en);
    exp_t e;
    logic [7:0] r, ns;
    @(negedge clk);
    op = o; opa = a; opb = b; cin = ci; flag_mask = m; upd_en = en;
    model(o, a, b, ci, m, en, model_st, r, ns);
    e.res = r; e.st = ns; e.tag = en ? tag_of(o) : "R10";
    if (m != 8'hFF && en) e.tag = {e.tag, "/R9"};
    sb.push_back(e);
    model_st = ns;
  endtask

  task automatic preset(input logic vflag, input logic cflag);
    drive(5'd0, vflag ? 8'h40 : 8'h00, vflag ? 8'h40 : 8'h00, 1'b0, 8'hFF, 1'b1);
    drive(cflag ? 5'd15 : 5'd14, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b1);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (result !== e.res || status !== e.st) begin
          errors++;
          $display("FAIL %s: op=%0d result=%h status=%h expected result=%h status=%h",
                   e.tag, op, result, status, e.res, e.st);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!driving_done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0; op = 5'd0; opa = 8'h00; opb = 8'h00; cin = 1'b0;
    flag_mask = 8'hFF; upd_en = 1'b0;
    model_st = 8'h20;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (status !== 8'h20) begin
      errors++;
      $display("FAIL R11: status in reset=%h expected=%h", status, 8'h20);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (status !== 8'h20) begin
      errors++;
      $display("FAIL R11: status after reset=%h expected=%h", status, 8'h20);
    end

    // R1 add: signed overflow, carry with zero, carry-in
    drive(5'd0, 8'h50, 8'h50, 1'b0, 8'hFF, 1'b1);
    drive(5'd0, 8'hFF, 8'h01, 1'b0, 8'hFF, 1'b1);
    drive(5'd0, 8'h7F, 8'h00, 1'b1, 8'hFF, 1'b1);
    drive(5'd0, 8'h90, 8'h90, 1'b1, 8'hFF, 1'b1);
    // R2 subtract: borrow, no borrow, overflow
    drive(5'd1, 8'h00, 8'h01, 1'b1, 8'hFF, 1'b1);
    drive(5'd1, 8'h50, 8'hF0, 1'b1, 8'hFF, 1'b1);
    drive(5'd1, 8'h80, 8'h01, 1'b1, 8'hFF, 1'b1);
    drive(5'd1, 8'h10, 8'h10, 1'b0, 8'hFF, 1'b1);
    // R3 logic and transfers keep V and C
    for (int k = 0; k < 6; k++) begin
      logic [4:0] lo;
      lo = (k < 3) ? 5'(k + 2) : ((k == 3) ? 5'd9 : ((k == 4) ? 5'd10 : 5'd13));
      preset(1'b1, 1'b1);
      drive(lo, 8'hF0, 8'h0F, 1'b0, 8'hFF, 1'b1);
      drive(lo, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b1);
      drive(lo, 8'hFF, 8'hFF, 1'b1, 8'hFF, 1'b1);
    end
    // R4 shifts, R5 rotates
    preset(1'b0, 1'b0);
    drive(5'd5, 8'h81, 8'h00, 1'b1, 8'hFF, 1'b1);
    drive(5'd5, 8'h80, 8'h00, 1'b0, 8'hFF, 1'b1);
    drive(5'd6, 8'hFF, 8'h00, 1'b1, 8'hFF, 1'b1);
    drive(5'd6, 8'h01, 8'h00, 1'b0, 8'hFF, 1'b1);
    drive(5'd7, 8'h80, 8'h00, 1'b1, 8'hFF, 1'b1);
    drive(5'd7, 8'h40, 8'h00, 1'b0, 8'hFF, 1'b1);
    drive(5'd8, 8'h01, 8'h00, 1'b1, 8'hFF, 1'b1);
    drive(5'd8, 8'h02, 8'h00, 1'b0, 8'hFF, 1'b1);
    // R6 compare: equal, less, greater, V untouched
    preset(1'b1, 1'b0);
    drive(5'd11, 8'h42, 8'h42, 1'b0, 8'hFF, 1'b1);
    drive(5'd11, 8'h10, 8'h20, 1'b1, 8'hFF, 1'b1);
    drive(5'd11, 8'hF0, 8'h01, 1'b0, 8'hFF, 1'b1);
    // R7 bit test with C preset
    preset(1'b0, 1'b1);
    drive(5'd12, 8'h0F, 8'hC0, 1'b0, 8'hFF, 1'b1);
    drive(5'd12, 8'h01, 8'h41, 1'b0, 8'hFF, 1'b1);
    drive(5'd12, 8'hFF, 8'h80, 1'b0, 8'hFF, 1'b1);
    // R8 single flag operations
    for (int k = 14; k <= 20; k++) begin
      preset(1'b1, 1'b1);
      drive(5'(k), 8'h5A, 8'hA5, 1'b0, 8'hFF, 1'b1);
      drive(5'((k % 2 == 0) ? 18 : 17), 8'h00, 8'h00, 1'b0, 8'hFF, 1'b1);
    end
    // R9 partial masks
    drive(5'd0, 8'hFF, 8'h01, 1'b0, 8'h02, 1'b1);
    drive(5'd1, 8'h00, 8'h01, 1'b1, 8'h80, 1'b1);
    drive(5'd15, 8'h00, 8'h00, 1'b0, 8'hFE, 1'b1);
    drive(5'd12, 8'h00, 8'hFF, 1'b0, 8'h40, 1'b1);
    // R10 update disabled
    drive(5'd0, 8'hFF, 8'h01, 1'b0, 8'hFF, 1'b0);
    drive(5'd15, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b0);
    // R12 unused codes
    for (int k = 21; k < 32; k++) drive(5'(k), 8'h3C, 8'hC3, 1'b1, 8'hFF, 1'b1);
    // mixed random traffic
    for (int k = 0; k < 400; k++) begin
      logic [7:0] m;
      m = ($urandom_range(3) == 0) ? 8'($urandom) : 8'hFF;
      drive(5'($urandom_range(31)), 8'($urandom), 8'($urandom), 1'($urandom),
            m, ($urandom_range(4) != 0));
    end
    @(negedge clk);
    upd_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    driving_done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule